// File: doc/BRIEF.md
# UART host register bank

This block is the processor-facing register file of a 16450-class serial port. A host reaches eight byte-wide registers through a 3-bit offset, a write strobe, a read strobe and separate 8-bit write and read buses. Behind the offsets sit a 16-bit baud divisor, an interrupt enable mask, an interrupt identification code, line control, modem control, line status, modem status and a scratch byte. One interrupt output summarises the pending causes.

On the serial side the block pulses a transmit strobe with the byte the host wrote. It takes received bytes with a valid pulse and takes line-break events. Modem status lines arrive as plain levels. A hidden transmit-pending flag drives the transmit interrupt. Reading the identification code acknowledges that flag, and rewriting the enable mask re-arms it. A loopback bit in modem control folds the modem-control outputs back into the modem status read value.

Top module: `uart_regbank`

## Requirements
- R1: While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. The receive buffer, the enable mask and the transmit strobe are left alone. While that bit is clear, those offsets reach the data and enable registers.
- R2: A write to the enable register (offset 1) keeps only bits 3:0. Bits 7:4 read back as zero. Bit 0 enables the receive interrupt and bit 1 enables the transmit interrupt.
- R3: The identification value at offset 2 is chosen as follows. It is 0x04 when data-ready is set and bit 0 of the enable register is set. Failing that, it is 0x02 when transmit-pending is set and bit 1 of the enable register is set. Otherwise it is 0x01. `irq` is high exactly when the value differs from 0x01.
- R4: A read of offset 2 that returns a value whose low three bits are 0x02 clears transmit-pending. A read that returns 0x04 leaves it set.
- R5: A write to the enable register while line status bit 5 is set makes transmit-pending set.
- R6: A data write (offset 0, line control bit 7 clear) raises `txStrobe` for the single following cycle, with `txByte` holding the written byte. It also sets transmit-pending and line status bits 5 and 6.
- R7: A received byte is taken into the receive buffer only while line status bit 0 (data-ready) is clear, and taking it sets that bit. A receive-buffer read clears line status bit 0 and bit 4 (break).
- R8: A break event loads 0x00 into the receive buffer and sets line status bits 4 and 0.
- R9: Modem control (offset 4) keeps bits 4:0. When bit 4 (loopback) is set, a read of offset 6 returns modem control bits 3:2 in bits 7:6, bit 0 in bit 5 and bit 1 in bit 4, with zeros below.
- R10: After reset, the enable, line control and modem control registers read 0x00. Identification reads 0x01, line status reads 0x60, modem status reads 0xB0, and `irq` and `txStrobe` are low.
- R11: Outside loopback, offset 6 returns the modem inputs one cycle after they change, `modemIn[3:0]` in bits 7:4 with bits 3:0 zero.
- R12: Writes to offsets 5 and 6 change nothing. Offset 7 stores and returns any byte.
- R13: A read strobe held high over several cycles causes its side effects only at the first sampled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Write strobe, one write per sampled cycle |
| rdEn | input | 1 | Read strobe, side effects on its first sampled cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current offset |
| irq | output | 1 | Interrupt request |
| txStrobe | output | 1 | One-cycle pulse per transmitted byte |
| txByte | output | 8 | Byte accompanying txStrobe |
| rxValid | input | 1 | Received byte valid |
| rxByte | input | 8 | Received byte |
| rxBreak | input | 1 | Line break event |
| modemIn | input | 4 | Modem status levels, carrier, ring, data-set-ready, clear-to-send from high to low |

## Verification
The bench builds the block with the package defaults: 8-bit data, a 3-bit offset, a 4-bit enable mask, 5 kept modem control bits and 4 modem lines. With these values every one of the eight offsets is reachable. Both banks behind the divisor-latch bit, every identification code and the loopback bit remapping can then be driven and observed at the read port. The fixed widths also place the receive-over-transmit priority, the acknowledge-by-read of the transmit cause and the single-effect held read strobe all within a few dozen accesses.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int IER_W   = 4;
  localparam int MCR_W   = 5;
  localparam int MODEM_W = 4;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IID  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSR  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

  localparam int LCR_LATCH_BIT = 7;
  localparam int MCR_LOOP_BIT  = 4;

  localparam logic [DATA_W-1:0] IID_NONE  = 8'h01;
  localparam logic [DATA_W-1:0] IID_TX    = 8'h02;
  localparam logic [DATA_W-1:0] IID_RX    = 8'h04;
  localparam logic [DATA_W-1:0] MSR_RESET = 8'hB0;

  typedef struct packed {
    logic wrTxData;
    logic wrDivLo;
    logic wrDivHi;
    logic wrIer;
    logic wrLcr;
    logic wrMcr;
    logic wrScr;
    logic rdRxBuf;
    logic rdIid;
  } regStrobes_t;
endpackage

// File: rtl/uart_regbank_ctrl.sv
module uart_regbank_ctrl
  import uart_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              latchSel,
  output regStrobes_t       strb
);
  logic rdPrev;
  logic rdFirst;

  always_ff @(posedge clk) begin
    if (!rstN) rdPrev <= 1'b0;
    else       rdPrev <= rdEn;
  end

  // side effects of a read only on the first sampled cycle of the strobe
  assign rdFirst = rdEn && !rdPrev;

  always_comb begin
    strb          = '0;
    strb.wrTxData = wrEn && (addr == OFS_DATA) && !latchSel;
    strb.wrDivLo  = wrEn && (addr == OFS_DATA) &&  latchSel;
    strb.wrDivHi  = wrEn && (addr == OFS_IER)  &&  latchSel;
    strb.wrIer    = wrEn && (addr == OFS_IER)  && !latchSel;
    strb.wrLcr    = wrEn && (addr == OFS_LCR);
    strb.wrMcr    = wrEn && (addr == OFS_MCR);
    strb.wrScr    = wrEn && (addr == OFS_SCR);
    strb.rdRxBuf  = rdFirst && (addr == OFS_DATA) && !latchSel;
    strb.rdIid    = rdFirst && (addr == OFS_IID);
  end

  // R13: a held read strobe yields one side-effect pulse
  p_rd_once_r13: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdRxBuf || strb.rdIid) |=> !(strb.rdRxBuf || strb.rdIid));

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/uart_regbank_dp.sv
module uart_regbank_dp
  import uart_regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        strb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rxValid,
  input  logic [DATA_W-1:0]  rxByte,
  input  logic               rxBreak,
  input  logic [MODEM_W-1:0] modemIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic               txStrobe,
  output logic [DATA_W-1:0]  txByte,
  output logic               latchSel
);
  logic [DATA_W-1:0] divLo, divHi, lineCtl, scratch, rxBuf, modemStat;
  logic [IER_W-1:0]  enMask;
  logic [MCR_W-1:0]  modemCtl;
  logic              dataReady, breakSeen, holdEmpty, txEmpty, txPending;
  logic [DATA_W-1:0] iidVal, lineStat, loopStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLo     <= '0;
      divHi     <= '0;
      lineCtl   <= '0;
      scratch   <= '0;
      enMask    <= '0;
      modemCtl  <= '0;
      txByte    <= '0;
      txStrobe  <= 1'b0;
      holdEmpty <= 1'b1;
      txEmpty   <= 1'b1;
      txPending <= 1'b0;
      modemStat <= MSR_RESET;
    end else begin
      if (strb.wrDivLo) divLo    <= wrData;
      if (strb.wrDivHi) divHi    <= wrData;
      if (strb.wrLcr)   lineCtl  <= wrData;
      if (strb.wrScr)   scratch  <= wrData;
      if (strb.wrIer)   enMask   <= wrData[IER_W-1:0];
      if (strb.wrMcr)   modemCtl <= wrData[MCR_W-1:0];
      txStrobe <= strb.wrTxData;
      if (strb.wrTxData) begin
        txByte    <= wrData;
        holdEmpty <= 1'b1;
        txEmpty   <= 1'b1;
      end
      if (strb.wrTxData || (strb.wrIer && holdEmpty))
        txPending <= 1'b1;
      else if (strb.rdIid && (iidVal[2:0] == IID_TX[2:0]))
        txPending <= 1'b0;
      modemStat <= {modemIn, {(DATA_W-MODEM_W){1'b0}}};
    end
  end

  // receive side: break has priority, a byte waits for an empty buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf     <= '0;
      dataReady <= 1'b0;
      breakSeen <= 1'b0;
    end else begin
      if (strb.rdRxBuf) begin
        dataReady <= 1'b0;
        breakSeen <= 1'b0;
      end
      if (rxBreak) begin
        rxBuf     <= '0;
        dataReady <= 1'b1;
        breakSeen <= 1'b1;
      end else if (rxValid && !dataReady) begin
        rxBuf     <= rxByte;
        dataReady <= 1'b1;
      end
    end
  end

  always_comb begin
    if (dataReady && enMask[0])      iidVal = IID_RX;
    else if (txPending && enMask[1]) iidVal = IID_TX;
    else                             iidVal = IID_NONE;
  end

  assign irq      = (iidVal != IID_NONE);
  assign latchSel = lineCtl[LCR_LATCH_BIT];
  assign lineStat = {1'b0, txEmpty, holdEmpty, breakSeen, 3'b000, dataReady};
  assign loopStat = {modemCtl[3:2], modemCtl[0], modemCtl[1], 4'b0000};

  always_comb begin
    case (addr)
      OFS_DATA: rdData = latchSel ? divLo : rxBuf;
      OFS_IER:  rdData = latchSel ? divHi : {{(DATA_W-IER_W){1'b0}}, enMask};
      OFS_IID:  rdData = iidVal;
      OFS_LCR:  rdData = lineCtl;
      OFS_MCR:  rdData = {{(DATA_W-MCR_W){1'b0}}, modemCtl};
      OFS_LSR:  rdData = lineStat;
      OFS_MSR:  rdData = modemCtl[MCR_LOOP_BIT] ? loopStat : modemStat;
      default:  rdData = scratch;
    endcase
  end

  p_rx_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && enMask[0]) |-> irq);

  p_tx_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdIid && (rdData == IID_TX)) |=> !txPending);

  p_rearm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIer && holdEmpty) |=> txPending);

  p_tx_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTxData |=> (txStrobe && (txByte == $past(wrData))));

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && !strb.rdRxBuf && !rxBreak) |=> (dataReady && $stable(rxBuf)));

  p_break_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxBreak |=> (breakSeen && dataReady && (rxBuf == '0)));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic               txStrobe,
  output logic [DATA_W-1:0]  txByte,
  input  logic               rxValid,
  input  logic [DATA_W-1:0]  rxByte,
  input  logic               rxBreak,
  input  logic [MODEM_W-1:0] modemIn
);
  regStrobes_t strb;
  logic        latchSel;

  uart_regbank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .latchSel(latchSel), .strb(strb)
  );

  uart_regbank_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .rxValid(rxValid), .rxByte(rxByte), .rxBreak(rxBreak), .modemIn(modemIn),
    .rdData(rdData), .irq(irq), .txStrobe(txStrobe), .txByte(txByte),
    .latchSel(latchSel)
  );

  p_ier_upper_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!latchSel && (addr == OFS_IER)) |-> (rdData[DATA_W-1:IER_W] == '0));
endmodule

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       isRd;
    logic [2:0] ofs;
    logic [7:0] dat;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 42;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd3, 8'h00, 8'h00, 4'd10},  // R10 line control
    '{1'b1, 3'd1, 8'h00, 8'h00, 4'd10},  // R10 enable
    '{1'b1, 3'd4, 8'h00, 8'h00, 4'd10},  // R10 modem control
    '{1'b1, 3'd2, 8'h00, 8'h01, 4'd10},  // R10 identification
    '{1'b1, 3'd5, 8'h00, 8'h60, 4'd10},  // R10 line status
    '{1'b1, 3'd6, 8'h00, 8'hB0, 4'd10},  // R10 modem status
    '{1'b0, 3'd7, 8'hA5, 8'h00, 4'd12},  // R12 scratch
    '{1'b1, 3'd7, 8'h00, 8'hA5, 4'd12},
    '{1'b0, 3'd7, 8'h3C, 8'h00, 4'd12},
    '{1'b1, 3'd7, 8'h00, 8'h3C, 4'd12},
    '{1'b0, 3'd5, 8'hFF, 8'h00, 4'd12},  // R12 ignored write
    '{1'b1, 3'd5, 8'h00, 8'h60, 4'd12},
    '{1'b0, 3'd6, 8'h00, 8'h00, 4'd12},
    '{1'b1, 3'd6, 8'h00, 8'hB0, 4'd12},
    '{1'b0, 3'd3, 8'h80, 8'h00, 4'd1},   // R1 latch access on
    '{1'b0, 3'd0, 8'h34, 8'h00, 4'd1},
    '{1'b0, 3'd1, 8'h12, 8'h00, 4'd1},
    '{1'b1, 3'd0, 8'h00, 8'h34, 4'd1},
    '{1'b1, 3'd1, 8'h00, 8'h12, 4'd1},
    '{1'b1, 3'd3, 8'h00, 8'h80, 4'd1},
    '{1'b0, 3'd3, 8'h03, 8'h00, 4'd1},
    '{1'b1, 3'd1, 8'h00, 8'h00, 4'd1},   // R1 enable untouched
    '{1'b0, 3'd1, 8'hFF, 8'h00, 4'd2},   // R2
    '{1'b1, 3'd1, 8'h00, 8'h0F, 4'd2},
    '{1'b1, 3'd2, 8'h00, 8'h02, 4'd3},   // R3 transmit cause
    '{1'b1, 3'd2, 8'h00, 8'h01, 4'd4},   // R4 acknowledged
    '{1'b0, 3'd1, 8'h02, 8'h00, 4'd5},   // R5 re-arm
    '{1'b1, 3'd2, 8'h00, 8'h02, 4'd5},
    '{1'b1, 3'd2, 8'h00, 8'h01, 4'd4},
    '{1'b0, 3'd3, 8'h80, 8'h00, 4'd1},
    '{1'b1, 3'd0, 8'h00, 8'h34, 4'd1},
    '{1'b1, 3'd1, 8'h00, 8'h12, 4'd1},
    '{1'b0, 3'd3, 8'h03, 8'h00, 4'd1},
    '{1'b0, 3'd4, 8'hFF, 8'h00, 4'd9},   // R9
    '{1'b1, 3'd4, 8'h00, 8'h1F, 4'd9},
    '{1'b1, 3'd6, 8'h00, 8'hF0, 4'd9},
    '{1'b0, 3'd4, 8'h15, 8'h00, 4'd9},
    '{1'b1, 3'd6, 8'h00, 8'h60, 4'd9},
    '{1'b0, 3'd4, 8'h1A, 8'h00, 4'd9},
    '{1'b1, 3'd6, 8'h00, 8'h90, 4'd9},
    '{1'b0, 3'd4, 8'h00, 8'h00, 4'd9},
    '{1'b1, 3'd6, 8'h00, 8'hB0, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq, txStrobe;
  logic [7:0] txByte;
  logic       rxValid = 1'b0, rxBreak = 1'b0;
  logic [7:0] rxByte = '0;
  logic [3:0] modemIn = 4'b1011;

  int  nChecks = 0;
  int  nFails  = 0;
  logic done = 1'b0;

  uart_regbank uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .txStrobe(txStrobe),
    .txByte(txByte), .rxValid(rxValid), .rxByte(rxByte), .rxBreak(rxBreak),
    .modemIn(modemIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic rxPulse(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R10 irq low", {7'b0, irq}, 8'h00);
    check("R10 txStrobe low", {7'b0, txStrobe}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRd) begin
        rd(VECS[i].ofs, v);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
      end else begin
        wr(VECS[i].ofs, VECS[i].dat);
      end
    end

    // R6: transmit write
    wr(3'd0, 8'h5A);
    check("R6 strobe", {7'b0, txStrobe}, 8'h01);
    check("R6 byte", txByte, 8'h5A);
    @(negedge clk);
    check("R6 strobe single", {7'b0, txStrobe}, 8'h00);
    check("R6 irq raised", {7'b0, irq}, 8'h01);
    rdChk(3'd2, 8'h02, "R6 pending");
    rdChk(3'd5, 8'h60, "R6 status");
    check("R4 irq dropped", {7'b0, irq}, 8'h00);

    // R7: receive path
    wr(3'd1, 8'h01);
    rxPulse(8'h3C);
    rdChk(3'd5, 8'h61, "R7 data ready");
    check("R3 rx irq", {7'b0, irq}, 8'h01);
    rdChk(3'd2, 8'h04, "R3 rx cause");
    rxPulse(8'h77);
    rdChk(3'd0, 8'h3C, "R7 byte kept");
    rdChk(3'd5, 8'h60, "R7 cleared");
    check("R7 irq low", {7'b0, irq}, 8'h00);

    // R3 priority, R4 no clear on rx cause
    wr(3'd1, 8'h03);
    rxPulse(8'h11);
    rdChk(3'd2, 8'h04, "R3 rx over tx");
    rdChk(3'd0, 8'h11, "R7 byte");
    rdChk(3'd2, 8'h02, "R4 tx kept");
    rdChk(3'd2, 8'h01, "R4 tx cleared");

    // R8: break
    @(negedge clk); rxBreak = 1'b1;
    @(negedge clk); rxBreak = 1'b0;
    rdChk(3'd5, 8'h71, "R8 status");
    rdChk(3'd0, 8'h00, "R8 buffer");
    rdChk(3'd5, 8'h60, "R7 break cleared");

    // R11: modem inputs
    @(negedge clk); modemIn = 4'b0101;
    @(negedge clk);
    rdChk(3'd6, 8'h50, "R11 track");
    modemIn = 4'b1011;
    @(negedge clk);
    rdChk(3'd6, 8'hB0, "R11 restore");

    // R13: held read strobe
    rxPulse(8'h21);
    @(negedge clk);
    addr = 3'd0; rdEn = 1'b1;
    #1 check("R13 first data", rdData, 8'h21);
    @(negedge clk); rxValid = 1'b1; rxByte = 8'h42;
    @(negedge clk); rxValid = 1'b0;
    @(negedge clk); rdEn = 1'b0;
    rdChk(3'd5, 8'h61, "R13 ready kept");
    rdChk(3'd0, 8'h42, "R13 new byte");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule